// File: doc/BRIEF.md
# Reed-Solomon Syndrome and Erasure Front End

This block is the receive-side front end of a Reed-Solomon decoder over GF(2^8) with field polynomial x^8 + x^7 + x^2 + x + 1 (0x187). A received block of `cfg_n` bytes streams in one byte per accepted beat. Each byte may carry an erasure mark. While the bytes arrive, the block keeps one Horner accumulator for each generator root alpha^(120+j). For j from 0 to `cfg_r`-1 the accumulator evaluates the received polynomial at that root. The first byte of the block is the highest-order coefficient. Alongside the syndromes, the block records the locator exponent of every erased byte and keeps a running count of erasures.

One cycle after the last byte of a block has been accepted, `done` pulses for one clock. At that point the syndromes, the zero-syndrome flag, the erasure count, the erasure positions and the erasure-budget flag are all valid. They stay unchanged until the first byte of the next block is accepted. A later stage, which is not part of this block, uses these results to locate and correct errors. Correction is possible only when the number of erasures plus twice the number of errors is at most `cfg_r`. Errors count per byte: any number of wrong bits in one byte is a single error.

The input side follows valid/ready rules. A byte transfers on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` is low in reset and high at all times after reset, so the block never applies back-pressure. The source may drop `in_valid` for any number of cycles, inside a block or between blocks. `cfg_r` (2 to 20) and `cfg_n` (`cfg_r`+1 to 255) must stay constant from the first byte of a block until its `done`.

Top module: `rs_syn_eras_front`

## Requirements
- R1: While `rst_n` is low, `in_ready` is 0. After reset, `done` is 0, `eras_cnt` is 0, `eras_over` is 0, and `in_ready` is 1 from the first clock after release.
- R2: Syndrome j, on `syn_out[8j+7:8j]`, equals the XOR over i of r_i·alpha^((120+j)(N-1-i)) in the 0x187 field, where alpha = 0x02, r_i is the i-th accepted byte of the block (i = 0 first), and N = `cfg_n`.
- R3: Every syndrome slot j with j >= `cfg_r` reads 0.
- R4: `done` is high for exactly one cycle, namely the cycle after the edge that accepts byte N-1 of a block.
- R5: `syn_zero` is 1 exactly when all `cfg_r` syndromes are zero. This holds for every valid codeword, including a shifted generator polynomial. A single byte corrupted in several bits clears it.
- R6: `eras_cnt` equals the number of accepted bytes of the current block that had `in_erase` high.
- R7: The k-th erased byte of a block, in arrival order, stores N-1-i in `eras_pos[8k+7:8k]` (i is its index). Slots at or beyond `eras_cnt` read 0. Only the first 20 erasures are stored, but all erasures are counted.
- R8: `eras_over` is 1 exactly when `eras_cnt` > `cfg_r`.
- R9: Cycles with `in_valid` low change no result. A block sent with idle gaps gives the same results as the same block sent without gaps.
- R10: The first byte of a new block discards all erasure state and syndrome state from the previous block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_r | input | 5 | Number of check bytes R (2..20) |
| cfg_n | input | 8 | Block length N in bytes (R+1..255) |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_data | input | 8 | Received byte |
| in_erase | input | 1 | Erasure mark for the byte on `in_data` |
| done | output | 1 | One-clock strobe: results of the finished block are valid |
| syn_out | output | 160 | Syndromes, slot j at bits 8j+7:8j |
| syn_zero | output | 1 | All R syndromes are zero |
| eras_cnt | output | 8 | Number of erased bytes in the block |
| eras_pos | output | 160 | Erasure locator exponents, slot k at bits 8k+7:8k |
| eras_over | output | 1 | Erasure count exceeds R |

## Verification
Each result comes from one register stage. A byte accepted at edge t appears in the accumulators, the count and the position slots after edge t. `done` is high in the cycle after the edge that accepted the last byte. The bench drives every input on the falling edge. It checks `done` and all block results on the falling edge right after the last beat, and it checks that `done` has dropped one falling edge later. Each expected syndrome comes from direct power-sum evaluation with a table of alpha powers, not from Horner's rule. Codewords are built by multiplying out the generator polynomial in the bench.

// File: rtl/rs_front_pkg.sv
package rs_front_pkg;
  typedef logic [7:0] sym_t;

  localparam sym_t GF_RED = 8'h87;  // low byte of 0x187

  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t x;
    sym_t p;
    x = a;
    p = '0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? GF_RED : 8'h00);
    end
    return p;
  endfunction

  function automatic sym_t gf_alpha_pow(input int e);
    sym_t v;
    v = 8'h01;
    for (int i = 0; i < (e % 255); i++) v = gf_mul(v, 8'h02);
    return v;
  endfunction
endpackage

// File: rtl/rs_syn_cell.sv
module rs_syn_cell
  import rs_front_pkg::*;
#(
  parameter int ROOT_EXP = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic first,
  input  sym_t din,
  output sym_t acc
);
  localparam sym_t ROOT = gf_alpha_pow(ROOT_EXP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (beat) acc <= first ? din : (gf_mul(acc, ROOT) ^ din);
  end
endmodule

// File: rtl/rs_blk_ctl.sv
module rs_blk_ctl #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_n,
  input  logic             beat,
  output logic             first,
  output logic [LEN_W-1:0] pos,
  output logic             done
);
  logic [LEN_W-1:0] idx;
  logic             last;

  assign first = (idx == '0);
  assign last  = (idx == cfg_n - LEN_W'(1));
  assign pos   = cfg_n - LEN_W'(1) - idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= beat && last;
      if (beat) idx <= last ? '0 : idx + LEN_W'(1);
    end
  end
endmodule

// File: rtl/rs_eras_track.sv
module rs_eras_track
  import rs_front_pkg::*;
#(
  parameter int MAX_ERAS = 20,
  parameter int CNT_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  beat,
  input  logic                  first,
  input  logic                  erase,
  input  sym_t                  pos,
  output logic [CNT_W-1:0]      cnt,
  output logic [MAX_ERAS*8-1:0] pos_flat
);
  logic [CNT_W-1:0] cnt_base;

  assign cnt_base = first ? '0 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (beat) cnt <= cnt_base + CNT_W'(erase);
  end

  for (genvar k = 0; k < MAX_ERAS; k++) begin : g_slot
    sym_t slot;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot <= '0;
      else if (beat) begin
        if (erase && cnt_base == CNT_W'(k)) slot <= pos;
        else if (first)                     slot <= '0;
      end
    end
    assign pos_flat[k*8 +: 8] = slot;
  end
endmodule

// File: rtl/rs_syn_eras_front.sv
module rs_syn_eras_front
  import rs_front_pkg::*;
#(
  parameter int MAX_R    = 20,
  parameter int MAX_ERAS = 20,
  parameter int FIRST_RT = 120
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [$clog2(MAX_R+1)-1:0]     cfg_r,
  input  logic [7:0]                     cfg_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [7:0]                     in_data,
  input  logic                           in_erase,
  output logic                           done,
  output logic [MAX_R*8-1:0]             syn_out,
  output logic                           syn_zero,
  output logic [7:0]                     eras_cnt,
  output logic [MAX_ERAS*8-1:0]          eras_pos,
  output logic                           eras_over
);
  localparam int RW = $clog2(MAX_R + 1);

  logic       beat;
  logic       first_beat;
  sym_t       cur_pos;
  logic [MAX_R-1:0] slot_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign beat = in_valid && in_ready;

  rs_blk_ctl #(.LEN_W(8)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_n(cfg_n), .beat(beat),
    .first(first_beat), .pos(cur_pos), .done(done)
  );

  for (genvar j = 0; j < MAX_R; j++) begin : g_syn
    sym_t acc;
    rs_syn_cell #(.ROOT_EXP(FIRST_RT + j)) u_cell (
      .clk(clk), .rst_n(rst_n), .beat(beat), .first(first_beat),
      .din(in_data), .acc(acc)
    );
    assign syn_out[j*8 +: 8] = (RW'(j) < cfg_r) ? acc : 8'h00;
    assign slot_zero[j]      = (syn_out[j*8 +: 8] == 8'h00);
  end

  assign syn_zero = &slot_zero;

  rs_eras_track #(.MAX_ERAS(MAX_ERAS), .CNT_W(8)) u_eras (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first_beat),
    .erase(in_erase), .pos(cur_pos), .cnt(eras_cnt), .pos_flat(eras_pos)
  );

  assign eras_over = (eras_cnt > 8'(cfg_r));
endmodule

// File: rtl/rs_syn_eras_front_chk.sv
module rs_syn_eras_front_chk #(
  parameter int MAX_ERAS = 20
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  in_erase,
  input logic                  first_beat,
  input logic                  done,
  input logic [7:0]            eras_cnt,
  input logic [MAX_ERAS*8-1:0] eras_pos
);
  p_ready_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  p_done_after_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_ready));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_erase && !first_beat) |=> $stable(eras_cnt));

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_erase && !first_beat) |=> eras_cnt == $past(eras_cnt) + 8'd1);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($stable(eras_cnt) && $stable(eras_pos)));
endmodule

bind rs_syn_eras_front rs_syn_eras_front_chk #(.MAX_ERAS(MAX_ERAS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_erase(in_erase), .first_beat(first_beat), .done(done),
  .eras_cnt(eras_cnt), .eras_pos(eras_pos)
);

// File: tb/rs_syn_eras_front_tb.sv
module rs_syn_eras_front_tb;
  localparam int MR = 20;
  localparam int ME = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [4:0]        cfg_r = 5'd2;
  logic [7:0]        cfg_n = 8'd3;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [7:0]        in_data = '0;
  logic              in_erase = 1'b0;
  logic              done;
  logic [MR*8-1:0]   syn_out;
  logic              syn_zero;
  logic [7:0]        eras_cnt;
  logic [ME*8-1:0]   eras_pos;
  logic              eras_over;

  int checks = 0;
  int errors = 0;

  logic [7:0] blk_d [0:255];
  logic       blk_e [0:255];
  logic [7:0] apow  [0:254];
  logic [7:0] gpoly [0:20];

  always #4 clk = ~clk;

  rs_syn_eras_front u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_r(cfg_r), .cfg_n(cfg_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_erase(in_erase), .done(done), .syn_out(syn_out),
    .syn_zero(syn_zero), .eras_cnt(eras_cnt), .eras_pos(eras_pos),
    .eras_over(eras_over)
  );

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] prod;
    prod = '0;
    for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
    for (int k = 15; k >= 8; k--) if (prod[k]) prod = prod ^ (16'h187 << (k - 8));
    return prod[7:0];
  endfunction

  function automatic logic [7:0] exp_syn(input int j, input int n);
    logic [7:0] s;
    s = '0;
    for (int i = 0; i < n; i++) s = s ^ bmul(blk_d[i], apow[((120 + j) * (n - 1 - i)) % 255]);
    return s;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_block(input int n, input int r, input bit gaps);
    @(negedge clk);
    cfg_n = 8'(n);
    cfg_r = 5'(r);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = blk_d[i];
      in_erase = blk_e[i];
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_erase = 1'b0;
  endtask

  task automatic check_done_then_drop();
    check(done === 1'b1, "R4 done after last byte", int'(done), 1);
    @(negedge clk);
    check(done === 1'b0, "R4 done one cycle", int'(done), 0);
  endtask

  task automatic check_syn(input int n, input int r, input string req);
    int bad;
    int first_bad;
    bad = 0;
    first_bad = 0;
    for (int j = 0; j < MR; j++) begin
      if (syn_out[j*8 +: 8] !== ((j < r) ? exp_syn(j, n) : 8'h00)) begin
        if (bad == 0) first_bad = j;
        bad++;
      end
    end
    check(bad == 0, req, int'(syn_out[first_bad*8 +: 8]),
          (first_bad < r) ? int'(exp_syn(first_bad, n)) : 0);
  endtask

  task automatic clear_blk();
    for (int i = 0; i < 256; i++) begin
      blk_d[i] = '0;
      blk_e[i] = 1'b0;
    end
  endtask

  task automatic t_reset();
    check(in_ready === 1'b0, "R1 ready low in reset", int'(in_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);
    check(done === 1'b0 && eras_cnt === 8'd0 && eras_over === 1'b0,
          "R1 reset outputs", int'(eras_cnt), 0);
  endtask

  task automatic t_random();
    clear_blk();
    for (int i = 0; i < 20; i++) blk_d[i] = 8'($urandom);
    send_block(20, 4, 1'b0);
    check_syn(20, 4, "R2 R3 random block syndromes");
    check(syn_zero === 1'b0, "R5 random block not zero", int'(syn_zero), 0);
    check_done_then_drop();
    clear_blk();
    for (int i = 0; i < 255; i++) blk_d[i] = 8'($urandom);
    send_block(255, 20, 1'b0);
    check_syn(255, 20, "R2 full length block");
    check_done_then_drop();
  endtask

  task automatic t_codeword();
    int r;
    int n;
    r = 6;
    n = 12;
    for (int k = 0; k <= 20; k++) gpoly[k] = '0;
    gpoly[0] = 8'h01;
    for (int j = 0; j < r; j++) begin
      for (int k = j + 1; k >= 1; k--) gpoly[k] = gpoly[k-1] ^ bmul(apow[120 + j], gpoly[k]);
      gpoly[0] = bmul(apow[120 + j], gpoly[0]);
    end
    clear_blk();
    for (int i = 0; i < n; i++) blk_d[i] = (n - 1 - i <= r) ? gpoly[n - 1 - i] : 8'h00;
    send_block(n, r, 1'b0);
    check(syn_zero === 1'b1, "R5 codeword gives zero syndromes", int'(syn_zero), 1);
    check_syn(n, r, "R2 codeword syndromes");
    check_done_then_drop();
    blk_d[8] = blk_d[8] ^ 8'hB5;
    send_block(n, r, 1'b0);
    check(syn_zero === 1'b0, "R5 multi-bit byte error detected", int'(syn_zero), 0);
    check_syn(n, r, "R2 corrupted codeword syndromes");
    check_done_then_drop();
  endtask

  task automatic t_erasures();
    clear_blk();
    for (int i = 0; i < 30; i++) blk_d[i] = 8'($urandom);
    blk_e[2] = 1'b1;
    blk_e[7] = 1'b1;
    blk_e[29] = 1'b1;
    send_block(30, 5, 1'b0);
    check(eras_cnt === 8'd3, "R6 erasure count", int'(eras_cnt), 3);
    check(eras_pos[7:0] === 8'd27 && eras_pos[15:8] === 8'd22 && eras_pos[23:16] === 8'd0,
          "R7 erasure positions", int'(eras_pos[15:8]), 22);
    check(eras_pos[ME*8-1:24] === '0, "R7 unused slots zero", int'(eras_pos[31:24]), 0);
    check(eras_over === 1'b0, "R8 within budget", int'(eras_over), 0);
    check_done_then_drop();
  endtask

  task automatic t_overflow();
    clear_blk();
    blk_e[0] = 1'b1;
    blk_e[1] = 1'b1;
    blk_e[2] = 1'b1;
    send_block(10, 2, 1'b0);
    check(eras_over === 1'b1, "R8 three erasures over R=2", int'(eras_over), 1);
    check_done_then_drop();
    send_block(10, 3, 1'b0);
    check(eras_over === 1'b0, "R8 three erasures at R=3", int'(eras_over), 0);
    check_done_then_drop();
    clear_blk();
    for (int i = 0; i < 22; i++) blk_e[i + 10] = 1'b1;
    send_block(40, 20, 1'b0);
    check(eras_cnt === 8'd22, "R6 count past storage", int'(eras_cnt), 22);
    check(eras_pos[19*8 +: 8] === 8'd10, "R7 last stored slot", int'(eras_pos[19*8 +: 8]), 10);
    check(eras_over === 1'b1, "R8 22 over 20", int'(eras_over), 1);
    check_done_then_drop();
  endtask

  task automatic t_gaps();
    logic [MR*8-1:0] ref_syn;
    logic [ME*8-1:0] ref_pos;
    clear_blk();
    for (int i = 0; i < 17; i++) begin
      blk_d[i] = 8'($urandom);
      blk_e[i] = (i % 5 == 0);
    end
    send_block(17, 8, 1'b0);
    ref_syn = syn_out;
    ref_pos = eras_pos;
    check_done_then_drop();
    repeat (3) @(negedge clk);
    check(syn_out === ref_syn && eras_pos === ref_pos, "R9 idle keeps results",
          int'(syn_out[7:0]), int'(ref_syn[7:0]));
    send_block(17, 8, 1'b1);
    check(syn_out === ref_syn && eras_pos === ref_pos, "R9 gaps give same results",
          int'(syn_out[7:0]), int'(ref_syn[7:0]));
    check_syn(17, 8, "R2 block with gaps");
    check_done_then_drop();
  endtask

  task automatic t_restart();
    clear_blk();
    blk_e[3] = 1'b1;
    send_block(9, 4, 1'b0);
    check_done_then_drop();
    clear_blk();
    for (int i = 0; i < 9; i++) blk_d[i] = 8'($urandom);
    send_block(9, 4, 1'b0);
    check(eras_cnt === 8'd0 && eras_pos === '0, "R10 erasure state cleared",
          int'(eras_cnt), 0);
    check_syn(9, 4, "R10 syndromes restart");
    check_done_then_drop();
  endtask

  initial begin
    apow[0] = 8'h01;
    for (int e = 1; e < 255; e++) apow[e] = bmul(apow[e-1], 8'h02);
    repeat (2) @(negedge clk);
    t_reset();
    t_random();
    t_codeword();
    t_erasures();
    t_overflow();
    t_gaps();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule